// File: doc/BRIEF.md
# Priority memory chip-select decoder

The block sits on the address bus of an 8-bit microcontroller. It compares each 16-bit address with programmable windows: several main flash sectors, several boot flash sectors, an SRAM window built from up to three separate range terms, and one I/O window. When two or more windows contain the address, three fixed priority tiers decide which one is selected. SRAM and I/O form the top tier, boot flash the middle tier and main flash the bottom tier. The block drives at most one select line, and only while the address strobe is valid.

Each window is an inclusive base/limit pair with an enable bit. The configuration is held on static input buses. Two windows in the same tier must never overlap, so the block reports such overlaps on error flags rather than arbitrating them silently. It also flags any flash window that is wider than its physical sector. By default the selects pass through one register stage.

Top module: `mem_csel_decoder`

## Requirements
- R1: An address inside any enabled SRAM term (the three terms are ORed) asserts sram_sel, whatever flash or I/O windows also contain it.
- R2: An address inside the enabled I/O window and outside every SRAM term asserts io_sel rather than any flash select. When SRAM and I/O both match, sram_sel wins.
- R3: An address inside an enabled boot sector and outside the top tier asserts that boot_sel bit, even when a main sector also contains it.
- R4: A main sector select bit is asserted only when no top-tier or boot window matches. Within a tier with illegal overlap, the lowest matching index wins.
- R5: No select is asserted when addr_valid is low or nothing matches. At most one bit of {fs_sel, boot_sel, sram_sel, io_sel} is ever high.
- R6: A window matches only when its enable bit is 1 and base <= addr <= limit, with both ends inclusive. A window whose base is above its limit never matches.
- R7: err_main_ovl, err_boot_ovl and err_sram_io_ovl go high while two enabled windows of main flash, of boot flash, or an SRAM term and the I/O window, share at least one address. These flags follow the configuration combinationally.
- R8: err_main_size[i] (err_boot_size[i]) goes high while enabled sector i spans limit-base+1 addresses, and that span exceeds MAIN_SECT_SIZE (BOOT_SECT_SIZE, 0x4000 and 0x2000 by default).
- R9: With REG_OUT=1 (default), the selects appear on the clock edge after the address is presented. An asserted rst_n low clears every select.
- R10: Consider this configuration: main sector 0 at 0x8000-0xBFFF, boot sector 0 at 0x8000-0x9FFF and SRAM term 0 at 0x8000-0x87FF. Then 0x8000-0x87FF selects SRAM, 0x8800-0x9FFF selects boot 0, and 0xA000-0xBFFF selects main 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Address strobe |
| addr | input | ADDR_W | Bus address |
| main_base | input | N_MAIN*ADDR_W | Main sector bases, sector i at [i*ADDR_W +: ADDR_W] |
| main_limit | input | N_MAIN*ADDR_W | Main sector inclusive limits |
| main_en | input | N_MAIN | Main sector enables |
| boot_base | input | N_BOOT*ADDR_W | Boot sector bases |
| boot_limit | input | N_BOOT*ADDR_W | Boot sector inclusive limits |
| boot_en | input | N_BOOT | Boot sector enables |
| sram_base | input | N_SRAM*ADDR_W | SRAM term bases |
| sram_limit | input | N_SRAM*ADDR_W | SRAM term inclusive limits |
| sram_en | input | N_SRAM | SRAM term enables |
| io_base | input | ADDR_W | I/O window base |
| io_limit | input | ADDR_W | I/O window inclusive limit |
| io_en | input | 1 | I/O window enable |
| fs_sel | output | N_MAIN | One-hot main sector select |
| boot_sel | output | N_BOOT | One-hot boot sector select |
| sram_sel | output | 1 | SRAM select |
| io_sel | output | 1 | I/O select |
| err_main_ovl | output | 1 | Main sectors overlap |
| err_boot_ovl | output | 1 | Boot sectors overlap |
| err_sram_io_ovl | output | 1 | SRAM term overlaps I/O window |
| err_main_size | output | N_MAIN | Main sector wider than physical size |
| err_boot_size | output | N_BOOT | Boot sector wider than physical size |

## Verification
The hardest situations to reach are the illegal ones. In these, two windows of one tier overlap and an SRAM term sits on the I/O window. The outputs must then stay one-hot while the error flags are high. The stimulus sets these up on purpose: it places a second main sector inside the first, a second boot sector inside the first, and an SRAM term across the I/O window. It then probes addresses in the shared part, so that lowest-index arbitration and SRAM-over-I/O are both seen at the ports. Boundary addresses one below, at, and one above each base and limit are swept. A long run of random addresses on a layered map follows.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // Inclusive window hit test; operands zero-extended to 32 bits.
  function automatic logic win_hit(logic [31:0] a, logic [31:0] lo,
                                   logic [31:0] hi, logic en);
    return en && (a >= lo) && (a <= hi);
  endfunction

  // Two enabled, well-formed windows share at least one address.
  function automatic logic win_overlap(logic [31:0] lo0, logic [31:0] hi0, logic en0,
                                       logic [31:0] lo1, logic [31:0] hi1, logic en1);
    return en0 && en1 && (lo0 <= hi0) && (lo1 <= hi1) && (lo0 <= hi1) && (lo1 <= hi0);
  endfunction

endpackage

// File: rtl/csd_window_bank.sv
module csd_window_bank #(
  parameter int ADDR_W = 16,
  parameter int N      = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [N*ADDR_W-1:0] base,
  input  logic [N*ADDR_W-1:0] limit,
  input  logic [N-1:0]        en,
  output logic [N-1:0]        hit
);
  import csd_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_win
    assign hit[i] = win_hit(32'(addr), 32'(base[i*ADDR_W +: ADDR_W]),
                            32'(limit[i*ADDR_W +: ADDR_W]), en[i]);
  end
endmodule

// File: rtl/csd_tier_audit.sv
module csd_tier_audit #(
  parameter int ADDR_W    = 16,
  parameter int N         = 4,
  parameter int SECT_SIZE = 16384
) (
  input  logic [N*ADDR_W-1:0] base,
  input  logic [N*ADDR_W-1:0] limit,
  input  logic [N-1:0]        en,
  output logic                ovl,
  output logic [N-1:0]        size_err
);
  import csd_pkg::*;

  localparam logic [ADDR_W:0] SPAN_MAX = (ADDR_W+1)'(SECT_SIZE - 1);

  always_comb begin
    ovl = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (win_overlap(32'(base[i*ADDR_W +: ADDR_W]), 32'(limit[i*ADDR_W +: ADDR_W]), en[i],
                        32'(base[j*ADDR_W +: ADDR_W]), 32'(limit[j*ADDR_W +: ADDR_W]), en[j]))
          ovl = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_size
    logic [ADDR_W-1:0] lo, hi;
    logic [ADDR_W:0]   span;
    assign lo          = base[i*ADDR_W +: ADDR_W];
    assign hi          = limit[i*ADDR_W +: ADDR_W];
    assign span        = {1'b0, hi} - {1'b0, lo};
    assign size_err[i] = en[i] && (lo <= hi) && (span > SPAN_MAX);
  end
endmodule

// File: rtl/csd_prio_pick.sv
module csd_prio_pick #(
  parameter int N_MAIN = 4,
  parameter int N_BOOT = 4
) (
  input  logic              sram_hit,
  input  logic              io_hit,
  input  logic [N_BOOT-1:0] boot_hit,
  input  logic [N_MAIN-1:0] main_hit,
  output logic [N_MAIN-1:0] fs_o,
  output logic [N_BOOT-1:0] boot_o,
  output logic              sram_o,
  output logic              io_o
);
  always_comb begin
    fs_o   = '0;
    boot_o = '0;
    sram_o = 1'b0;
    io_o   = 1'b0;
    if (sram_hit) begin
      sram_o = 1'b1;
    end else if (io_hit) begin
      io_o = 1'b1;
    end else if (|boot_hit) begin
      for (int i = N_BOOT - 1; i >= 0; i--) begin
        if (boot_hit[i]) begin
          boot_o    = '0;
          boot_o[i] = 1'b1;
        end
      end
    end else begin
      for (int i = N_MAIN - 1; i >= 0; i--) begin
        if (main_hit[i]) begin
          fs_o    = '0;
          fs_o[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mem_csel_decoder.sv
module mem_csel_decoder #(
  parameter int ADDR_W         = 16,
  parameter int N_MAIN         = 4,
  parameter int N_BOOT         = 4,
  parameter int N_SRAM         = 3,
  parameter int MAIN_SECT_SIZE = 16384,
  parameter int BOOT_SECT_SIZE = 8192,
  parameter bit REG_OUT        = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       addr_valid,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [N_MAIN*ADDR_W-1:0]   main_base,
  input  logic [N_MAIN*ADDR_W-1:0]   main_limit,
  input  logic [N_MAIN-1:0]          main_en,
  input  logic [N_BOOT*ADDR_W-1:0]   boot_base,
  input  logic [N_BOOT*ADDR_W-1:0]   boot_limit,
  input  logic [N_BOOT-1:0]          boot_en,
  input  logic [N_SRAM*ADDR_W-1:0]   sram_base,
  input  logic [N_SRAM*ADDR_W-1:0]   sram_limit,
  input  logic [N_SRAM-1:0]          sram_en,
  input  logic [ADDR_W-1:0]          io_base,
  input  logic [ADDR_W-1:0]          io_limit,
  input  logic                       io_en,
  output logic [N_MAIN-1:0]          fs_sel,
  output logic [N_BOOT-1:0]          boot_sel,
  output logic                       sram_sel,
  output logic                       io_sel,
  output logic                       err_main_ovl,
  output logic                       err_boot_ovl,
  output logic                       err_sram_io_ovl,
  output logic [N_MAIN-1:0]          err_main_size,
  output logic [N_BOOT-1:0]          err_boot_size
);
  import csd_pkg::*;

  localparam int SEL_W = N_MAIN + N_BOOT + 2;

  logic [N_MAIN-1:0] main_hit;
  logic [N_BOOT-1:0] boot_hit;
  logic [N_SRAM-1:0] sram_hit;
  logic              io_hit;

  csd_window_bank #(.ADDR_W(ADDR_W), .N(N_MAIN)) u_main_bank (
    .addr(addr), .base(main_base), .limit(main_limit), .en(main_en), .hit(main_hit));
  csd_window_bank #(.ADDR_W(ADDR_W), .N(N_BOOT)) u_boot_bank (
    .addr(addr), .base(boot_base), .limit(boot_limit), .en(boot_en), .hit(boot_hit));
  csd_window_bank #(.ADDR_W(ADDR_W), .N(N_SRAM)) u_sram_bank (
    .addr(addr), .base(sram_base), .limit(sram_limit), .en(sram_en), .hit(sram_hit));

  assign io_hit = win_hit(32'(addr), 32'(io_base), 32'(io_limit), io_en);

  // Configuration audit
  csd_tier_audit #(.ADDR_W(ADDR_W), .N(N_MAIN), .SECT_SIZE(MAIN_SECT_SIZE)) u_main_audit (
    .base(main_base), .limit(main_limit), .en(main_en),
    .ovl(err_main_ovl), .size_err(err_main_size));
  csd_tier_audit #(.ADDR_W(ADDR_W), .N(N_BOOT), .SECT_SIZE(BOOT_SECT_SIZE)) u_boot_audit (
    .base(boot_base), .limit(boot_limit), .en(boot_en),
    .ovl(err_boot_ovl), .size_err(err_boot_size));

  always_comb begin
    err_sram_io_ovl = 1'b0;
    for (int i = 0; i < N_SRAM; i++) begin
      if (win_overlap(32'(sram_base[i*ADDR_W +: ADDR_W]), 32'(sram_limit[i*ADDR_W +: ADDR_W]),
                      sram_en[i], 32'(io_base), 32'(io_limit), io_en))
        err_sram_io_ovl = 1'b1;
    end
  end

  // Priority resolution
  logic [N_MAIN-1:0] fs_pick;
  logic [N_BOOT-1:0] boot_pick;
  logic              sram_pick, io_pick;

  csd_prio_pick #(.N_MAIN(N_MAIN), .N_BOOT(N_BOOT)) u_pick (
    .sram_hit(|sram_hit), .io_hit(io_hit), .boot_hit(boot_hit), .main_hit(main_hit),
    .fs_o(fs_pick), .boot_o(boot_pick), .sram_o(sram_pick), .io_o(io_pick));

  // Next-state: strobe gating
  logic [SEL_W-1:0] sel_d, sel_q;
  always_comb begin
    sel_d = '0;
    if (addr_valid) sel_d = {fs_pick, boot_pick, sram_pick, io_pick};
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= sel_d;
    end
  end else begin : g_comb
    assign sel_q = sel_d;
  end

  assign {fs_sel, boot_sel, sram_sel, io_sel} = sel_q;
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int N_MAIN  = 4,
  parameter int N_BOOT  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_valid,
  input logic              io_en,
  input logic [N_MAIN-1:0] main_en,
  input logic [N_BOOT-1:0] boot_en,
  input logic [N_MAIN-1:0] fs_sel,
  input logic [N_BOOT-1:0] boot_sel,
  input logic              sram_sel,
  input logic              io_sel,
  input logic [N_MAIN-1:0] err_main_size,
  input logic [N_BOOT-1:0] err_boot_size
);
  logic any_sel;
  assign any_sel = sram_sel || io_sel || (|fs_sel) || (|boot_sel);

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fs_sel, boot_sel, sram_sel, io_sel}));

  // R9
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> !any_sel);

  // R8
  size_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_main_size & ~main_en) == '0) && ((err_boot_size & ~boot_en) == '0));

  if (REG_OUT) begin : g_reg_chk
    // R5
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_sel |-> $past(addr_valid));
    // R6
    io_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_sel |-> $past(io_en));
  end else begin : g_comb_chk
    // R5
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_sel |-> addr_valid);
    // R6
    io_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_sel |-> io_en);
  end
endmodule

bind mem_csel_decoder csd_checker #(.N_MAIN(N_MAIN), .N_BOOT(N_BOOT), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .io_en(io_en),
  .main_en(main_en), .boot_en(boot_en), .fs_sel(fs_sel), .boot_sel(boot_sel),
  .sram_sel(sram_sel), .io_sel(io_sel),
  .err_main_size(err_main_size), .err_boot_size(err_boot_size));

// File: tb/mem_csel_decoder_tb.sv
`timescale 1ns/1ps
module mem_csel_decoder_tb;
  localparam int AW = 16, NM = 4, NB = 4, NS = 3;
  localparam int MSZ = 16384, BSZ = 8192;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, addr_valid, io_en;
  logic [AW-1:0] addr, io_base, io_limit;
  logic [NM*AW-1:0] main_base, main_limit;
  logic [NB*AW-1:0] boot_base, boot_limit;
  logic [NS*AW-1:0] sram_base, sram_limit;
  logic [NM-1:0] main_en, fs_sel, err_main_size;
  logic [NB-1:0] boot_en, boot_sel, err_boot_size;
  logic [NS-1:0] sram_en;
  logic sram_sel, io_sel, err_main_ovl, err_boot_ovl, err_sram_io_ovl;

  mem_csel_decoder u_dut (.*);

  int mb[NM], ml[NM], bb[NB], bl[NB], sb[NS], sl[NS], ib, il;
  bit me[NM], be[NB], se[NS], ie;
  int errors = 0, checks = 0;
  logic [9:0] pend = '0;
  string pend_tag = "R9";

  function automatic bit inr(int a, int lo, int hi, bit e);
    return e && a >= lo && a <= hi;
  endfunction
  function automatic bit ovl(int l0, int h0, bit e0, int l1, int h1, bit e1);
    return e0 && e1 && l0 <= h0 && l1 <= h1 && !(h0 < l1 || h1 < l0);
  endfunction

  // Expected {fs[3:0], boot[3:0], sram, io}
  function automatic logic [9:0] model(int a, bit v);
    logic [9:0] r = '0;
    if (!v) return r;
    for (int k = 0; k < NS; k++) if (inr(a, sb[k], sl[k], se[k])) begin r[1] = 1; return r; end
    if (inr(a, ib, il, ie)) begin r[0] = 1; return r; end
    for (int k = 0; k < NB; k++) if (inr(a, bb[k], bl[k], be[k])) begin r[2+k] = 1; return r; end
    for (int k = 0; k < NM; k++) if (inr(a, mb[k], ml[k], me[k])) begin r[6+k] = 1; return r; end
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int k = 0; k < NM; k++) begin mb[k] = 1; ml[k] = 0; me[k] = 0; end
    for (int k = 0; k < NB; k++) begin bb[k] = 1; bl[k] = 0; be[k] = 0; end
    for (int k = 0; k < NS; k++) begin sb[k] = 1; sl[k] = 0; se[k] = 0; end
    ib = 1; il = 0; ie = 0;
  endtask

  task automatic push_cfg();
    for (int k = 0; k < NM; k++) begin
      main_base[k*AW +: AW] = AW'(mb[k]); main_limit[k*AW +: AW] = AW'(ml[k]); main_en[k] = me[k];
    end
    for (int k = 0; k < NB; k++) begin
      boot_base[k*AW +: AW] = AW'(bb[k]); boot_limit[k*AW +: AW] = AW'(bl[k]); boot_en[k] = be[k];
    end
    for (int k = 0; k < NS; k++) begin
      sram_base[k*AW +: AW] = AW'(sb[k]); sram_limit[k*AW +: AW] = AW'(sl[k]); sram_en[k] = se[k];
    end
    io_base = AW'(ib); io_limit = AW'(il); io_en = ie;
  endtask

  // Check the selects registered from the previous step, then apply new inputs.
  task automatic step(int a, bit v, string tag);
    @(negedge clk);
    check({fs_sel, boot_sel, sram_sel, io_sel} === pend, pend_tag, "selects",
          int'({fs_sel, boot_sel, sram_sel, io_sel}), int'(pend));
    addr = AW'(a); addr_valid = v;
    push_cfg();
    pend = model(a, v);
    pend_tag = tag;
    #1;
  endtask

  task automatic chk_err();
    bit mo = 0, bo = 0, so = 0;
    logic [NM-1:0] ms = '0;
    logic [NB-1:0] bs = '0;
    for (int i = 0; i < NM; i++) for (int j = i + 1; j < NM; j++)
      if (ovl(mb[i], ml[i], me[i], mb[j], ml[j], me[j])) mo = 1;
    for (int i = 0; i < NB; i++) for (int j = i + 1; j < NB; j++)
      if (ovl(bb[i], bl[i], be[i], bb[j], bl[j], be[j])) bo = 1;
    for (int i = 0; i < NS; i++) if (ovl(sb[i], sl[i], se[i], ib, il, ie)) so = 1;
    for (int i = 0; i < NM; i++) ms[i] = me[i] && mb[i] <= ml[i] && (ml[i] - mb[i] + 1) > MSZ;
    for (int i = 0; i < NB; i++) bs[i] = be[i] && bb[i] <= bl[i] && (bl[i] - bb[i] + 1) > BSZ;
    check({err_main_ovl, err_boot_ovl, err_sram_io_ovl} === {mo, bo, so}, "R7", "overlap flags",
          int'({err_main_ovl, err_boot_ovl, err_sram_io_ovl}), int'({mo, bo, so}));
    check({err_main_size, err_boot_size} === {ms, bs}, "R8", "size flags",
          int'({err_main_size, err_boot_size}), int'({ms, bs}));
  endtask

  task automatic probe(int a, string tag);
    int pts[6] = '{a - 1, a, a + 1, a + 2, a - 2, a + 3};
    foreach (pts[i]) if (pts[i] >= 0 && pts[i] <= 16'hFFFF) step(pts[i], 1, tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; addr_valid = 1'b0; addr = '0;
    clear_cfg(); push_cfg();
    repeat (3) @(negedge clk);
    check({fs_sel, boot_sel, sram_sel, io_sel} === 10'b0, "R9", "reset selects",
          int'({fs_sel, boot_sel, sram_sel, io_sel}), 0);
    chk_err();
    rst_n = 1'b1;

    // R10 layered reference map
    me[0] = 1; mb[0] = 'h8000; ml[0] = 'hBFFF;
    be[0] = 1; bb[0] = 'h8000; bl[0] = 'h9FFF;
    se[0] = 1; sb[0] = 'h8000; sl[0] = 'h87FF;
    step('h8000, 1, "R10"); chk_err();
    probe('h87FF, "R10"); probe('h9FFF, "R10"); probe('hBFFF, "R10");
    probe('h8000, "R6");

    // R5 strobe low
    step('h8100, 0, "R5"); step('hA000, 0, "R5"); step('h0000, 1, "R5");

    // R2 I/O over main; R1 second and third SRAM terms
    me[1] = 1; mb[1] = 'hC000; ml[1] = 'hFFFF;
    ie = 1; ib = 'hC000; il = 'hC0FF;
    se[2] = 1; sb[2] = 'h0100; sl[2] = 'h01FF;
    step('hC000, 1, "R2"); chk_err();
    probe('hC0FF, "R2"); probe('h0100, "R1"); probe('h01FF, "R1");
    se[1] = 1; sb[1] = 'hC080; sl[1] = 'hC0BF;
    step('hC090, 1, "R2"); chk_err();
    probe('hC080, "R1");
    se[1] = 0;

    // R6 disable boot 0, inverted window
    be[0] = 0;
    step('h8800, 1, "R6"); step('h9FFF, 1, "R6");
    be[0] = 1;
    be[3] = 1; bb[3] = 'h5000; bl[3] = 'h4000;
    step('h4800, 1, "R6"); step('h5000, 1, "R6");

    // R4 / R7 illegal intra-tier overlaps, lowest index wins
    me[2] = 1; mb[2] = 'hA000; ml[2] = 'hA0FF;
    step('hA000, 1, "R4"); chk_err(); probe('hA0FF, "R4");
    be[1] = 1; bb[1] = 'h9000; bl[1] = 'h90FF;
    step('h9000, 1, "R4"); chk_err(); probe('h90FF, "R3");
    me[2] = 0; be[1] = 0;
    step('hA010, 1, "R7"); chk_err();

    // R8 sector size limits
    me[3] = 1; mb[3] = 'h0000; ml[3] = 'h3FFF;
    step('h3FFF, 1, "R8"); chk_err();
    ml[3] = 'h4000;
    step('h4000, 1, "R8"); chk_err();
    be[2] = 1; bb[2] = 'h6000; bl[2] = 'h7FFF;
    step('h7000, 1, "R8"); chk_err();
    bl[2] = 'h8000;
    step('h7000, 1, "R8"); chk_err();
    bl[2] = 'h7FFF; ml[3] = 'h3FFF;

    // Random sweep over the layered map
    for (int n = 0; n < 400; n++)
      step(int'($urandom_range(0, 16'hFFFF)), ($urandom_range(0, 7) != 0), "R5");

    // R9 mid-run reset clears selects
    step('h8000, 1, "R1");
    @(negedge clk);
    rst_n = 1'b0; #1;
    check({fs_sel, boot_sel, sram_sel, io_sel} === 10'b0, "R9", "async reset",
          int'({fs_sel, boot_sel, sram_sel, io_sel}), 0);
    @(negedge clk); rst_n = 1'b1; pend = '0; pend_tag = "R9";
    addr_valid = 1'b0;
    step('h8000, 1, "R9");
    step('h0000, 0, "R9");
    summary();
  end
endmodule